// File: doc/BRIEF.md
# SD Host Command/Data Line Reset Controller

This block gives an SD/MMC host controller two self-clearing reset request bits: one for the command-path state machine and one for the data-path state machine. Software sets a bit by writing 1 to its position in the system-control word. The controller then holds the bit at 1 and drives a reset pulse into the selected path. The pulse lasts at least a fixed number of cycles and continues until that path reports that it is idle. When the pulse ends, the bit drops back to 0. A bit that reads 1 and later reads 0 therefore marks one complete reset procedure.

An optional hardware trigger starts the same procedure without software. A command timeout resets the command path. A data timeout, a data CRC error or a data end-bit error resets the data path. The two channels run independently of each other. The read view returns the two bits at the same positions as the write.

Top module: `sdh_line_rst_ctrl`

## Requirements
- R1: Bit 25 of the control word is the command-path reset request and bit 26 is the data-path reset request. `ctl_rdata` shows each bit at that same position, and all other read bits are 0.
- R2: A write with bit 25 (or bit 26) set makes the matching bit read 1 and asserts the matching reset output from the clock edge that samples the write.
- R3: Each reset output stays high for at least `MIN_PULSE` (default 4) consecutive cycles.
- R4: A reset output stays high until the path's idle input has been sampled high with the minimum already met. The bit and the output fall together at that edge, so the output length is max(`MIN_PULSE`, D+1) cycles when idle rises D cycles after the start.
- R5: Writing 0 to a reset bit has no effect.
- R6: A write of 1 to a channel whose reset is already running is ignored and does not lengthen the pulse.
- R7: With `auto_rst_en` high, a command-timeout event starts a command-path reset.
- R8: With `auto_rst_en` high, a data-timeout, data-CRC or data-end-bit event starts a data-path reset.
- R9: With `auto_rst_en` low, the error events start no reset.
- R10: The channels are independent: a request on one channel leaves the other channel's bit and output unchanged.
- R11: Asserting `rst_n` low at once clears both bits and deasserts both reset outputs. Reset is released on the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 32 | Write data; bits 25/26 request resets |
| ctl_rdata | output | 32 | Read view of the two reset bits |
| auto_rst_en | input | 1 | Enables error-triggered resets |
| ev_cmd_timeout | input | 1 | Command timeout event |
| ev_dat_timeout | input | 1 | Data timeout event |
| ev_dat_crc | input | 1 | Data CRC error event |
| ev_dat_endbit | input | 1 | Data end-bit error event |
| cmd_path_idle | input | 1 | Command path reports idle |
| dat_path_idle | input | 1 | Data path reports idle |
| cmd_path_rst | output | 1 | Reset pulse to the command path |
| dat_path_rst | output | 1 | Reset pulse to the data path |

## Verification
The assertions check on every cycle the rules that hold at each edge:
- the read view shows exactly the two bits (R1);
- a qualifying start turns a quiet channel busy on the next cycle (R2, R7, R8);
- a pulse never ends before its minimum length or while the path is busy (R3, R4);
- a quiet channel stays quiet when nothing targets it (R10).

Only the bench scenarios can show the following:
- the exact pulse length for a given idle delay;
- that a repeated write does not lengthen a running pulse (R6);
- that writing 0, or raising events while disabled, does nothing (R5, R9);
- that an asynchronous reset in mid-pulse clears everything at once (R11).

// File: rtl/sdh_rst_pkg.sv
package sdh_rst_pkg;
  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_PULSE = 2'd1,
    CH_DRAIN = 2'd2
  } ch_state_e;

  localparam int NUM_CH = 2;
  localparam int CH_CMD = 0;
  localparam int CH_DAT = 1;
endpackage

// File: rtl/sdh_rst_sync.sv
// Asynchronous assert, synchronous release of the active-low reset.
module sdh_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sdh_rst_trig.sv
// Combines software writes and enabled error events into per-channel starts.
module sdh_rst_trig
  import sdh_rst_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int CMD_BIT = 25,
  parameter int DAT_BIT = 26
) (
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             auto_en,
  input  logic             ev_cmd_to,
  input  logic             ev_dat_to,
  input  logic             ev_dat_crc,
  input  logic             ev_dat_ebit,
  output logic [NUM_CH-1:0] start_o
);
  logic sw_cmd, sw_dat, hw_cmd, hw_dat;

  always_comb begin
    sw_cmd = wr_en & wr_data[CMD_BIT];
    sw_dat = wr_en & wr_data[DAT_BIT];
    hw_cmd = auto_en & ev_cmd_to;
    hw_dat = auto_en & (ev_dat_to | ev_dat_crc | ev_dat_ebit);
    start_o = '0;
    start_o[CH_CMD] = sw_cmd | hw_cmd;
    start_o[CH_DAT] = sw_dat | hw_dat;
  end
endmodule

// File: rtl/sdh_rst_chan.sv
// One self-clearing reset channel: minimum pulse, then wait for path idle.
module sdh_rst_chan
  import sdh_rst_pkg::*;
#(
  parameter int MIN_PULSE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic idle_i,
  output logic busy_o
);
  localparam int CW = (MIN_PULSE > 1) ? $clog2(MIN_PULSE) : 1;
  localparam logic [CW-1:0] LAST = CW'(MIN_PULSE - 1);

  ch_state_e      st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (st_q)
      CH_IDLE: begin
        if (start_i) begin
          st_d   = CH_PULSE;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
      end
      CH_PULSE: begin
        if (cnt_q == LAST) begin
          st_d = idle_i ? CH_IDLE : CH_DRAIN;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      CH_DRAIN: begin
        if (idle_i) begin
          st_d = CH_IDLE;
        end
      end
      default: st_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CH_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign busy_o = (st_q != CH_IDLE);
endmodule

// File: rtl/sdh_line_rst_ctrl.sv
module sdh_line_rst_ctrl
  import sdh_rst_pkg::*;
#(
  parameter int REG_W     = 32,
  parameter int CMD_BIT   = 25,
  parameter int DAT_BIT   = 26,
  parameter int MIN_PULSE = 4,
  parameter int SYNC_STG  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [REG_W-1:0] ctl_wdata,
  output logic [REG_W-1:0] ctl_rdata,
  input  logic             auto_rst_en,
  input  logic             ev_cmd_timeout,
  input  logic             ev_dat_timeout,
  input  logic             ev_dat_crc,
  input  logic             ev_dat_endbit,
  input  logic             cmd_path_idle,
  input  logic             dat_path_idle,
  output logic             cmd_path_rst,
  output logic             dat_path_rst
);
  logic              rst_sync_n;
  logic [NUM_CH-1:0] start;
  logic [NUM_CH-1:0] idle;
  logic [NUM_CH-1:0] busy;

  sdh_rst_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sdh_rst_trig #(.REG_W(REG_W), .CMD_BIT(CMD_BIT), .DAT_BIT(DAT_BIT)) u_trig (
    .wr_en       (ctl_we),
    .wr_data     (ctl_wdata),
    .auto_en     (auto_rst_en),
    .ev_cmd_to   (ev_cmd_timeout),
    .ev_dat_to   (ev_dat_timeout),
    .ev_dat_crc  (ev_dat_crc),
    .ev_dat_ebit (ev_dat_endbit),
    .start_o     (start)
  );

  always_comb begin
    idle         = '0;
    idle[CH_CMD] = cmd_path_idle;
    idle[CH_DAT] = dat_path_idle;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    sdh_rst_chan #(.MIN_PULSE(MIN_PULSE)) u_chan (
      .clk     (clk),
      .rst_n   (rst_sync_n & rst_n),
      .start_i (start[g]),
      .idle_i  (idle[g]),
      .busy_o  (busy[g])
    );
  end

  always_comb begin
    ctl_rdata          = '0;
    ctl_rdata[CMD_BIT] = busy[CH_CMD];
    ctl_rdata[DAT_BIT] = busy[CH_DAT];
  end

  assign cmd_path_rst = busy[CH_CMD];
  assign dat_path_rst = busy[CH_DAT];
endmodule

// File: rtl/sdh_line_rst_ctrl_chk.sv
module sdh_line_rst_ctrl_chk #(
  parameter int REG_W     = 32,
  parameter int CMD_BIT   = 25,
  parameter int DAT_BIT   = 26,
  parameter int MIN_PULSE = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_we,
  input logic [REG_W-1:0] ctl_wdata,
  input logic [REG_W-1:0] ctl_rdata,
  input logic             auto_rst_en,
  input logic             ev_cmd_timeout,
  input logic             ev_dat_timeout,
  input logic             ev_dat_crc,
  input logic             ev_dat_endbit,
  input logic             cmd_path_idle,
  input logic             dat_path_idle,
  input logic             cmd_path_rst,
  input logic             dat_path_rst
);
  localparam logic [REG_W-1:0] BITS_MASK = (REG_W'(1) << CMD_BIT) | (REG_W'(1) << DAT_BIT);

  logic [2:0] age_q;
  logic       armed;
  logic [7:0] cmd_hi_q, dat_hi_q;
  logic       cmd_go, dat_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q    <= '0;
      cmd_hi_q <= '0;
      dat_hi_q <= '0;
    end else begin
      if (age_q != 3'd7) age_q <= age_q + 3'd1;
      cmd_hi_q <= cmd_path_rst ? ((cmd_hi_q == 8'hff) ? cmd_hi_q : cmd_hi_q + 8'd1) : 8'd0;
      dat_hi_q <= dat_path_rst ? ((dat_hi_q == 8'hff) ? dat_hi_q : dat_hi_q + 8'd1) : 8'd0;
    end
  end

  assign armed  = (age_q == 3'd7);
  assign cmd_go = (ctl_we & ctl_wdata[CMD_BIT]) | (auto_rst_en & ev_cmd_timeout);
  assign dat_go = (ctl_we & ctl_wdata[DAT_BIT]) |
                  (auto_rst_en & (ev_dat_timeout | ev_dat_crc | ev_dat_endbit));

  // R1: only the two request bits can ever read as 1
  a_r1_read_view: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata & ~BITS_MASK) == '0);

  // R2 / R7: a start on a quiet command channel makes it busy next cycle
  a_r2_cmd_start: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (cmd_go && !cmd_path_rst) |=> (cmd_path_rst && ctl_rdata[CMD_BIT]));

  // R2 / R8: same for the data channel
  a_r8_dat_start: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (dat_go && !dat_path_rst) |=> (dat_path_rst && ctl_rdata[DAT_BIT]));

  // R3: a pulse never ends before its minimum length
  a_r3_cmd_min: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $fell(cmd_path_rst) |-> (cmd_hi_q >= 8'(MIN_PULSE)));
  a_r3_dat_min: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $fell(dat_path_rst) |-> (dat_hi_q >= 8'(MIN_PULSE)));

  // R4: a pulse only ends once the path was seen idle
  a_r4_cmd_idle: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $fell(cmd_path_rst) |-> $past(cmd_path_idle));
  a_r4_dat_idle: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $fell(dat_path_rst) |-> $past(dat_path_idle));

  // R10: a quiet channel stays quiet without its own start
  a_r10_cmd_quiet: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (!cmd_path_rst && !cmd_go) |=> !cmd_path_rst);
  a_r10_dat_quiet: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (!dat_path_rst && !dat_go) |=> !dat_path_rst);
endmodule

bind sdh_line_rst_ctrl sdh_line_rst_ctrl_chk #(
  .REG_W(REG_W), .CMD_BIT(CMD_BIT), .DAT_BIT(DAT_BIT), .MIN_PULSE(MIN_PULSE)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ctl_we         (ctl_we),
  .ctl_wdata      (ctl_wdata),
  .ctl_rdata      (ctl_rdata),
  .auto_rst_en    (auto_rst_en),
  .ev_cmd_timeout (ev_cmd_timeout),
  .ev_dat_timeout (ev_dat_timeout),
  .ev_dat_crc     (ev_dat_crc),
  .ev_dat_endbit  (ev_dat_endbit),
  .cmd_path_idle  (cmd_path_idle),
  .dat_path_idle  (dat_path_idle),
  .cmd_path_rst   (cmd_path_rst),
  .dat_path_rst   (dat_path_rst)
);

// File: tb/test_sdh_line_rst_ctrl.sv
module test_sdh_line_rst_ctrl;
  localparam int CMD_B = 25;
  localparam int DAT_B = 26;

  // kind: 0 write cmd, 1 write dat, 2 write both, 3 cmd timeout ev, 4 dat crc ev,
  //       5 dat end-bit ev, 6 dat timeout ev, 7 events with auto off, 8 write zeros
  typedef struct packed {
    logic [3:0] kind;
    logic [7:0] dly;
    logic [7:0] exp_c;
    logic [7:0] exp_d;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{4'd0, 8'd0, 8'd4, 8'd0},   // R2 R3 R10
    '{4'd1, 8'd0, 8'd0, 8'd4},   // R2 R10
    '{4'd0, 8'd6, 8'd7, 8'd0},   // R4
    '{4'd1, 8'd3, 8'd0, 8'd4},   // R4 boundary: idle exactly at minimum
    '{4'd1, 8'd4, 8'd0, 8'd5},   // R4 one past minimum
    '{4'd2, 8'd9, 8'd10, 8'd10}, // R1 both
    '{4'd3, 8'd0, 8'd4, 8'd0},   // R7
    '{4'd4, 8'd2, 8'd0, 8'd4},   // R8 crc
    '{4'd5, 8'd5, 8'd0, 8'd6},   // R8 end-bit
    '{4'd6, 8'd0, 8'd0, 8'd4},   // R8 timeout
    '{4'd7, 8'd0, 8'd0, 8'd0},   // R9
    '{4'd8, 8'd0, 8'd0, 8'd0}    // R5
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_we;
  logic [31:0] ctl_wdata;
  logic [31:0] ctl_rdata;
  logic        auto_rst_en, ev_cmd_timeout, ev_dat_timeout, ev_dat_crc, ev_dat_endbit;
  logic        cmd_path_idle, dat_path_idle, cmd_path_rst, dat_path_rst;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  sdh_line_rst_ctrl i_sdh_line_rst_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .auto_rst_en(auto_rst_en), .ev_cmd_timeout(ev_cmd_timeout), .ev_dat_timeout(ev_dat_timeout),
    .ev_dat_crc(ev_dat_crc), .ev_dat_endbit(ev_dat_endbit),
    .cmd_path_idle(cmd_path_idle), .dat_path_idle(dat_path_idle),
    .cmd_path_rst(cmd_path_rst), .dat_path_rst(dat_path_rst)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic quiet();
    ctl_we = 1'b0; ctl_wdata = '0;
    ev_cmd_timeout = 1'b0; ev_dat_timeout = 1'b0; ev_dat_crc = 1'b0; ev_dat_endbit = 1'b0;
  endtask

  // Counts high cycles of both outputs after the stimulus edge; idles rise after dly edges.
  task automatic measure(input int dly, output int nc, output int nd, output int mism);
    nc = 0; nd = 0; mism = 0;
    for (int i = 0; i < 40; i++) begin
      if (cmd_path_rst) nc++;
      if (dat_path_rst) nd++;
      if (ctl_rdata[CMD_B] != cmd_path_rst || ctl_rdata[DAT_B] != dat_path_rst) mism++;
      if ((ctl_rdata & ~((32'd1 << CMD_B) | (32'd1 << DAT_B))) != 0) mism++;
      if (i == dly) begin cmd_path_idle = 1'b1; dat_path_idle = 1'b1; end
      @(posedge clk); @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int nc, nd, mm;
    quiet();
    auto_rst_en = 1'b0;
    cmd_path_idle = 1'b1; dat_path_idle = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    check("R11 reset cmd_path_rst", int'(cmd_path_rst), 0);
    check("R11 reset dat_path_rst", int'(dat_path_rst), 0);
    check("R1 reset ctl_rdata", int'(ctl_rdata), 0);

    for (int v = 0; v < NV; v++) begin
      cmd_path_idle = 1'b0; dat_path_idle = 1'b0;
      case (TBL[v].kind)
        4'd0: begin ctl_we = 1'b1; ctl_wdata = 32'd1 << CMD_B; end
        4'd1: begin ctl_we = 1'b1; ctl_wdata = 32'd1 << DAT_B; end
        4'd2: begin ctl_we = 1'b1; ctl_wdata = (32'd1 << CMD_B) | (32'd1 << DAT_B); end
        4'd3: begin auto_rst_en = 1'b1; ev_cmd_timeout = 1'b1; end
        4'd4: begin auto_rst_en = 1'b1; ev_dat_crc = 1'b1; end
        4'd5: begin auto_rst_en = 1'b1; ev_dat_endbit = 1'b1; end
        4'd6: begin auto_rst_en = 1'b1; ev_dat_timeout = 1'b1; end
        4'd7: begin auto_rst_en = 1'b0; ev_cmd_timeout = 1'b1; ev_dat_timeout = 1'b1;
                    ev_dat_crc = 1'b1; ev_dat_endbit = 1'b1; end
        default: begin ctl_we = 1'b1; ctl_wdata = ~((32'd1 << CMD_B) | (32'd1 << DAT_B)); end
      endcase
      @(posedge clk); @(negedge clk);
      quiet();
      measure(int'(TBL[v].dly), nc, nd, mm);
      check($sformatf("R3 R4 R7 R9 R10 vec%0d cmd length", v), nc, int'(TBL[v].exp_c));
      check($sformatf("R3 R4 R8 R5 R10 vec%0d dat length", v), nd, int'(TBL[v].exp_d));
      check($sformatf("R1 vec%0d read view", v), mm, 0);
      auto_rst_en = 1'b0;
      cmd_path_idle = 1'b1; dat_path_idle = 1'b1;
      @(negedge clk);
    end

    // R6: second write during a running reset does not extend it
    ctl_we = 1'b1; ctl_wdata = 32'd1 << CMD_B;
    @(posedge clk); @(negedge clk);
    nc = 0;
    if (cmd_path_rst) nc++;
    @(posedge clk); @(negedge clk);
    quiet();
    for (int i = 0; i < 20; i++) begin
      if (cmd_path_rst) nc++;
      @(posedge clk); @(negedge clk);
    end
    check("R6 rewrite during reset cmd length", nc, 4);

    // R11: asynchronous reset mid-pulse
    cmd_path_idle = 1'b0; dat_path_idle = 1'b0;
    ctl_we = 1'b1; ctl_wdata = (32'd1 << CMD_B) | (32'd1 << DAT_B);
    @(posedge clk); @(negedge clk);
    quiet();
    @(posedge clk); @(negedge clk);
    check("R11 pulse running before reset", int'(cmd_path_rst & dat_path_rst), 1);
    rst_n = 1'b0;
    #1;
    check("R11 async clear cmd_path_rst", int'(cmd_path_rst), 0);
    check("R11 async clear dat_path_rst", int'(dat_path_rst), 0);
    check("R11 async clear ctl_rdata", int'(ctl_rdata), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 stays clear after release", int'(cmd_path_rst | dat_path_rst), 0);
    cmd_path_idle = 1'b1; dat_path_idle = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule